// File: doc/BRIEF.md
# GPIO Event Detect Controller

This block samples a vector of general-purpose input pins, grouped in banks of 32, and records four kinds of per-pin event into sticky status bits: a rising edge, a falling edge, a high level and a low level. Each kind has its own enable register per bank. A status bit stays set until software writes a 1 to its position. Writing 1 clears only the chosen bits, so a driver that acknowledges one pin at a time never loses an event that arrives on another pin while it handles the first.

Each bank drives its own interrupt line, which is high while any status bit in that bank is set. A combined line is high while any status bit in any bank is set. Software reaches the enables and the status through a plain synchronous write port and a combinational read port. The address is split into a bank number (bits above bit 2) and a 3-bit field code (bits 2:0).

Top module: `gpio_evt_ctrl`

## Requirements
- R1: When the rise-enable bit of a pin is 1, a 0-to-1 change on that pin sets its status bit.
- R2: When the fall-enable bit of a pin is 1, a 1-to-0 change on that pin sets its status bit.
- R3: When the high-enable bit of a pin is 1 and the pin is 1, its status bit is set.
- R4: When the low-enable bit of a pin is 1 and the pin is 0, its status bit is set.
- R5: A pin whose four enable bits are all 0 never sets its status bit, whatever the pin does.
- R6: A write of 1 to a status bit position clears that bit. A write of 0 leaves the bit unchanged. Other bits, including one set by an event in the same cycle, are not disturbed.
- R7: A status bit set by an edge or a level stays set after the pin returns, until it is cleared by a write.
- R8: If an enabled level is still present when its status bit is cleared, the bit reads 1 again right after the clearing write.
- R9: If a new event and a clearing write hit the same bit in the same clock cycle, the bit ends up 1.
- R10: Interrupt line irq_bank_o[b] is 1 exactly when some status bit of bank b is 1.
- R11: irq_any_o is 1 exactly when some status bit in any bank is 1.
- R12: While rst_n is low, every status and enable register reads 0 and all interrupt outputs are 0.
- R13: The register address is bank*8 + field. The field codes are 0 for status (write-1-to-clear), 1 for rise enable, 2 for fall enable, 3 for high enable and 4 for low enable. An enable reads back the value written to it. Field codes 5 to 7 read 0, and writes to them are ignored.
- R14: A pin change applied between clock edges reaches its status bit at the third rising clock edge that follows, and not earlier. This covers two synchronizer stages and one detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | BANKS*32 | Asynchronous pin inputs; bank b is bits b*32+31..b*32 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address, bank*8 + field |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address, bank*8 + field |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_bank_o | output | BANKS | Per-bank interrupt lines |
| irq_any_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default of two banks, so the bank part of the address is a single bit. With two banks the bench can pit one bank's rising edges against the other bank's falling edges in the same pin pattern. It can also show that the combined line follows either bank on its own. The 64-pin width also brings the clear-while-event race and the level re-set within reach in the lower bank, while the upper bank stays idle.

// File: rtl/gpio_evt_pkg.sv
// Package: shared constants and field codes for the GPIO event controller.
// Assumes a fixed bank width of 32 pins and a 3-bit field code in the address.
package gpio_evt_pkg;
    localparam int BANK_W = 32;
    localparam int FLD_W  = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_STATUS = 3'd0,
        FLD_RISE   = 3'd1,
        FLD_FALL   = 3'd2,
        FLD_HIGH   = 3'd3,
        FLD_LOW    = 3'd4
    } gpio_fld_e;
endpackage

// File: rtl/gpio_evt_sync.sv
// Module: two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_evt_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the raw inputs, then re-register them once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/gpio_evt_bank.sv
// Module: one bank of event detection: four enable registers, an edge
// history register and the sticky write-1-to-clear status register.
// Assumes pin_s_i is already synchronized to clk.
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     pin_s_i,
    input  logic             wr_en,
    input  logic [FLD_W-1:0] wr_fld,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     status_o,
    output logic [W-1:0]     rise_en_o,
    output logic [W-1:0]     fall_en_o,
    output logic [W-1:0]     high_en_o,
    output logic [W-1:0]     low_en_o
);
    logic [W-1:0] rise_q, fall_q, high_q, low_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] ev;
    logic [W-1:0] clr;

    // Enable registers: loaded by writes to their field code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            high_q <= '0;
            low_q  <= '0;
        end else if (wr_en) begin
            case (wr_fld)
                FLD_RISE: rise_q <= wr_data;
                FLD_FALL: fall_q <= wr_data;
                FLD_HIGH: high_q <= wr_data;
                FLD_LOW:  low_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // History of the synchronized pins, one cycle behind, for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s_i;
    end

    // Event and clear vectors for this cycle.
    always_comb begin
        ev  = (rise_q & pin_s_i & ~prev_q)
            | (fall_q & ~pin_s_i & prev_q)
            | (high_q & pin_s_i)
            | (low_q  & ~pin_s_i);
        clr = (wr_en && wr_fld == FLD_STATUS) ? wr_data : '0;
    end

    // Sticky status: clears apply first, new events win over them.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | ev;
    end

    assign status_o  = stat_q;
    assign rise_en_o = rise_q;
    assign fall_en_o = fall_q;
    assign high_en_o = high_q;
    assign low_en_o  = low_q;
endmodule

// File: rtl/gpio_evt_ctrl.sv
// Module: top of the GPIO event controller. Synchronizes the pins,
// instantiates one detection bank per group of 32, decodes register
// writes, muxes reads and forms the interrupt lines.
// Assumes rd_addr and wr_addr are bank*8 + field code.
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int BANKS    = 2,
    parameter int NUM_PINS = BANKS * BANK_W,
    parameter int BSEL_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    parameter int ADDR_W   = BSEL_W + FLD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BANK_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BANK_W-1:0]   rd_data,
    output logic [BANKS-1:0]    irq_bank_o,
    output logic                irq_any_o
);
    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] stat_all;
    logic [NUM_PINS-1:0] en_all;
    logic [BANK_W-1:0]   rd_vec [BANKS][5];

    gpio_evt_sync #(.W(NUM_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic              bank_wr;
        logic [BANK_W-1:0] st, re, fe, he, le;

        assign bank_wr = wr_en && (wr_addr[ADDR_W-1:FLD_W] == BSEL_W'(b));

        gpio_evt_bank #(.W(BANK_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s_i   (pin_s[b*BANK_W +: BANK_W]),
            .wr_en     (bank_wr),
            .wr_fld    (wr_addr[FLD_W-1:0]),
            .wr_data   (wr_data),
            .status_o  (st),
            .rise_en_o (re),
            .fall_en_o (fe),
            .high_en_o (he),
            .low_en_o  (le)
        );

        assign stat_all[b*BANK_W +: BANK_W] = st;
        assign en_all[b*BANK_W +: BANK_W]   = re | fe | he | le;
        assign rd_vec[b][0] = st;
        assign rd_vec[b][1] = re;
        assign rd_vec[b][2] = fe;
        assign rd_vec[b][3] = he;
        assign rd_vec[b][4] = le;
        assign irq_bank_o[b] = |st;
    end

    assign irq_any_o = |irq_bank_o;

    // Read mux: selected bank and field, zero for unmapped codes.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_addr[ADDR_W-1:FLD_W] == BSEL_W'(b)) begin
                for (int f = 0; f < 5; f++) begin
                    if (rd_addr[FLD_W-1:0] == FLD_W'(f)) rd_data = rd_vec[b][f];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_evt_chk.sv
// Module: assertion checker for gpio_evt_ctrl, attached by bind.
// Assumes status and combined enables are visible as stat_all and en_all.
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int ADDR_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [BANK_W-1:0]         wr_data,
    input logic [BANKS*BANK_W-1:0]   stat_all,
    input logic [BANKS*BANK_W-1:0]   en_all,
    input logic [BANKS-1:0]          irq_bank_o,
    input logic                      irq_any_o
);
    logic [BANKS*BANK_W-1:0] clr_vec;

    // Bits targeted by a status-clearing write this cycle.
    always_comb begin
        clr_vec = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (wr_en && wr_addr == ADDR_W'(b * 8)) clr_vec[b*BANK_W +: BANK_W] = wr_data;
        end
    end

    // R11
    irq_any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o == (|stat_all));

    for (genvar b = 0; b < BANKS; b++) begin : g_chk
        // R10
        irq_bank_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_bank_o[b] == (|stat_all[b*BANK_W +: BANK_W]));
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_all) & ~$past(clr_vec)) & ~stat_all) == '0);

    // R5
    no_enable_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_all & ~$past(stat_all)) & ~$past(en_all)) == '0);
endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.BANKS(BANKS), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stat_all   (stat_all),
    .en_all     (en_all),
    .irq_bank_o (irq_bank_o),
    .irq_any_o  (irq_any_o)
);

// File: tb/gpio_evt_ctrl_tb_top.sv
module gpio_evt_ctrl_tb_top;
    localparam int BANKS = 2;
    localparam int NP    = 64;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [1:0]    irq_bank;
    logic          irq_any;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_evt_ctrl #(.BANKS(BANKS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_bank_o (irq_bank),
        .irq_any_o  (irq_any)
    );

    // Table: {pins[63:0], expected bank1 status, expected bank0 status}
    // with bank0 rise-enabled on all pins and bank1 fall-enabled on all pins.
    localparam logic [127:0] VEC [6] = '{
        {64'h0000_0000_0000_0000, 32'h0000_0000, 32'h0000_0000},
        {64'h0000_00F0_0000_000F, 32'h0000_0000, 32'h0000_000F},
        {64'h0000_0000_0000_0000, 32'h0000_00F0, 32'h0000_0000},
        {64'hFFFF_0000_A5A5_0000, 32'h0000_0000, 32'hA5A5_0000},
        {64'h0000_FFFF_0000_0001, 32'hFFFF_0000, 32'h0000_0001},
        {64'h0000_0000_0000_0000, 32'h0000_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a negedge; write lands on the next posedge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Pin change and a write that lands on the edge where the event sets.
    task automatic coincide(input int pin, input logic [AW-1:0] a, input logic [31:0] d);
        pins[pin] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 irq_bank", {30'd0, irq_bank}, 32'd0);
        chk("R12 irq_any", {31'd0, irq_any}, 32'd0);
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f < 5; f++) begin
                rd(AW'(b * 8 + f), v);
                chk("R12 register", v, 32'd0);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: read back and unmapped code
        wr(4'd9, 32'h1234_5678);
        rd(4'd9, v);  chk("R13 rise enable bank1", v, 32'h1234_5678);
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, v);  chk("R13 unmapped code", v, 32'd0);
        rd(4'd0, v);  chk("R13 unmapped write no effect", v, 32'd0);
        wr(4'd9, 32'd0);

        // R1 R2 R10 R11: table walk
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd10, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) begin
            pins = VEC[i][127:64];
            settle();
            rd(4'd0, v); chk("R1 bank0 rise status", v, VEC[i][31:0]);
            rd(4'd8, v); chk("R2 bank1 fall status", v, VEC[i][63:32]);
            chk("R10 irq per bank", {30'd0, irq_bank},
                {30'd0, |VEC[i][63:32], |VEC[i][31:0]});
            chk("R11 irq combined", {31'd0, irq_any}, {31'd0, |VEC[i][63:0]});
            wr(4'd0, 32'hFFFF_FFFF);
            wr(4'd8, 32'hFFFF_FFFF);
        end
        wr(4'd1, 32'd0);
        wr(4'd10, 32'd0);

        // R5: no enables, pins toggle
        pins = '1;
        settle();
        pins = '0;
        settle();
        rd(4'd0, v); chk("R5 bank0 untouched", v, 32'd0);
        rd(4'd8, v); chk("R5 bank1 untouched", v, 32'd0);
        chk("R5 irq_any low", {31'd0, irq_any}, 32'd0);

        // R3 R8 R7: high level on bank0 pin 5
        wr(4'd3, 32'h0000_0020);
        pins[5] = 1'b1;
        settle();
        rd(4'd0, v); chk("R3 high level sets", v, 32'h0000_0020);
        chk("R10 bank0 line", {30'd0, irq_bank}, 32'd1);
        chk("R11 combined line", {31'd0, irq_any}, 32'd1);
        wr(4'd0, 32'h0000_0020);
        rd(4'd0, v); chk("R8 level re-sets after clear", v, 32'h0000_0020);
        pins[5] = 1'b0;
        settle();
        rd(4'd0, v); chk("R7 level bit sticky", v, 32'h0000_0020);
        wr(4'd0, 32'h0000_0020);
        rd(4'd0, v); chk("R6 clear after level gone", v, 32'd0);
        wr(4'd3, 32'd0);

        // R4: low level on bank1 pin 2 (pin 34 low)
        wr(4'd12, 32'h0000_0004);
        settle();
        rd(4'd8, v); chk("R4 low level sets", v, 32'h0000_0004);
        chk("R10 bank1 line", {30'd0, irq_bank}, 32'd2);
        pins[34] = 1'b1;
        settle();
        wr(4'd8, 32'h0000_0004);
        rd(4'd8, v); chk("R4 cleared once high", v, 32'd0);
        wr(4'd12, 32'd0);
        pins[34] = 1'b0;
        settle();

        // R7 R6: sticky edges, write-0 and selective clear
        wr(4'd1, 32'h0000_0007);
        pins[1:0] = 2'b11;
        settle();
        pins[1:0] = 2'b00;
        settle();
        rd(4'd0, v); chk("R7 edge bits sticky", v, 32'h0000_0003);
        wr(4'd0, 32'd0);
        rd(4'd0, v); chk("R6 write 0 no effect", v, 32'h0000_0003);
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, v); chk("R6 clear bit0 only", v, 32'h0000_0002);
        coincide(0, 4'd0, 32'h0000_0002);
        settle();
        rd(4'd0, v); chk("R6 other-pin event kept", v, 32'h0000_0001);

        // R9: event and clear on the same bit, same cycle
        coincide(1, 4'd0, 32'h0000_0002);
        settle();
        rd(4'd0, v); chk("R9 set wins over clear", v, 32'h0000_0003);
        pins[1:0] = 2'b00;
        settle();
        wr(4'd0, 32'hFFFF_FFFF);

        // R14: latency of three edges
        pins[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd(4'd0, v); chk("R14 not set after two edges", v, 32'd0);
        @(posedge clk);
        @(negedge clk);
        rd(4'd0, v); chk("R14 set at third edge", v, 32'h0000_0004);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule